// File: doc/BRIEF.md
# JTAG TAP Master Engine

This block is a hardware master for a JTAG scan chain. It drives the test clock, test mode select, test data in and the active-low test reset pins, and it samples test data out. A host hands it one command at a time through a valid/ready port. Each command is one operation: chain reset, full bring-up, idle clocking, entry into the instruction or data shift path, a shift of up to 32 bits, or closing an open shift. Every command ends with a single done pulse. For a shift, the captured word is valid at that pulse.

The engine does not model the full sixteen-state TAP controller. It only emits short, fixed TMS patterns and keeps a four-valued navigation record: reset, committed, running or in-data. While the record says in-data, a shift is still open. Any navigation or idle command first closes that shift by itself, with two TMS-high clocks. The test clock comes from a half-period divider counted in system clocks. Each test clock pulse is one half-period low, one half-period high, and one half-period low again. TMS and TDI change only while the test clock is low.

Top module: `jtag_tap_master`

## Requirements
- R1: Out of system reset the pins read test clock 0, TMS 0, TDI 1 and test reset 0. The command port reads ready 1, done 0 and capture word 0.
- R2: Opcode 0 (chain reset) drives test reset low and TDI high. It then clocks TMS 1,1,1,1,1,0,0 and sets the navigation record to reset, so a following close-shift emits no clocks.
- R3: Opcode 5 (close shift) emits two TMS=1 clocks only when the record is in-data, and then sets it to committed. In any other state it completes with no clocks.
- R4: Opcode 3 (data path) emits TMS 1,0 and opcode 2 (instruction path) emits TMS 1,1,0. Each is preceded by the two-clock close when the record is in-data, and each leaves the record in-data.
- R5: Opcode 1 (idle) with count N first closes an open shift and then emits N clocks with TMS=0. It leaves the record running, and N=0 emits only the close.
- R6: Opcode 4 (shift) with count N emits min(N,32) clocks with TMS=0. Before clock b, TDI carries bit b of the write word, least significant first. The TDO level at the rising edge of clock b lands in capture bit b, and the capture bits above the count read 0. N=0 emits no clocks.
- R7: Each test clock pulse is low for at least HALF_PERIOD system clocks before it rises and high for exactly HALF_PERIOD. TMS and TDI hold steady while the test clock is high.
- R8: Opcode 6 (bring-up) runs the R2 pattern with test reset low, then raises test reset, then emits BRINGUP_IDLE clocks with TMS=0, and leaves the record running.
- R9: After opcode 0 the test reset pin stays low past done. It rises, with the test clock low, when the next command other than 0 or 6 is accepted.
- R10: Ready is high exactly when no command is in progress, and it is already high in the cycle done pulses. Every accepted command gives exactly one single-cycle done. The unused opcode 7 completes with no clocks and a capture of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle, command taken this cycle if valid |
| cmd_op_i | input | 3 | Opcode (see requirements) |
| cmd_len_i | input | CNT_W | Clock or bit count for idle and shift |
| cmd_wdata_i | input | DW | Shift-out word, least significant bit first |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured TDO word |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the chain |
| trst_n_o | output | 1 | Active-low test reset |
| tdo_i | input | 1 | Test data from the chain |

## Verification
Two things can land in the same cycle. One is the done pulse of a finishing command. The other is the acceptance of the next command, because ready is already high when done shows. The bench provokes this by holding valid high with a shift queued behind a data-path entry that needs an auto-close. It judges the outcome by three checks: the done-cycle ready level, the drop of ready one cycle later, and the captured word. That word must come from TDO positions counted after the four navigation clocks of the first command. Within a single command, the auto-close and the navigation pattern run back to back. The scoreboard checks that the TMS sequence holds both, in order.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    // Command opcodes carried on cmd_op_i.
    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_RUN     = 3'd1,
        OP_IR      = 3'd2,
        OP_DR      = 3'd3,
        OP_SHIFT   = 3'd4,
        OP_COMMIT  = 3'd5,
        OP_BRINGUP = 3'd6
    } op_e;

    // Tracked navigation record.
    typedef enum logic [1:0] {
        NAV_RST    = 2'd0,
        NAV_COMMIT = 2'd1,
        NAV_RUN    = 2'd2,
        NAV_DATA   = 2'd3
    } nav_e;

    // Fixed TMS patterns, least significant bit is sent first.
    localparam logic [6:0] PAT_RESET = 7'b0011111;
    localparam logic [6:0] PAT_IR    = 7'b0000011;
    localparam logic [6:0] PAT_DR    = 7'b0000001;
    localparam logic [6:0] PAT_CLOSE = 7'b0000011;

endpackage

// File: rtl/jtag_tck_pulser.sv
module jtag_tck_pulser #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic tck_o,
    output logic rise_o,
    output logic fin_o,
    output logic busy_o
);
    localparam int CW = $clog2(HALF_PERIOD) + 1;

    typedef enum logic [1:0] {P_IDLE, P_PRE, P_HIGH, P_POST} ph_e;

    typedef struct packed {
        ph_e           ph;
        logic [CW-1:0] cnt;
        logic          tck;
    } pul_t;

    pul_t q, d;
    logic last;

    assign last   = (q.cnt == CW'(HALF_PERIOD - 1));
    assign rise_o = (q.ph == P_PRE)  && last;
    assign fin_o  = (q.ph == P_POST) && last;
    assign busy_o = (q.ph != P_IDLE);
    assign tck_o  = q.tck;

    always_comb begin
        d = q;
        unique case (q.ph)
            P_IDLE: begin
                if (start_i) begin
                    d.ph  = P_PRE;
                    d.cnt = '0;
                end
            end
            P_PRE: begin
                if (last) begin
                    d.ph  = P_HIGH;
                    d.cnt = '0;
                    d.tck = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            P_HIGH: begin
                if (last) begin
                    d.ph  = P_POST;
                    d.cnt = '0;
                    d.tck = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (last) begin
                    d.ph  = start_i ? P_PRE : P_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r7_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !tck_o);
    a_r7_fin_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !tck_o);

endmodule

// File: rtl/jtag_cmd_plan.sv
module jtag_cmd_plan
    import jtag_tap_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DW           = 32,
    parameter int CTR_W        = 8,
    parameter int BRINGUP_IDLE = 100
) (
    input  logic [2:0]       op_i,
    input  logic [CNT_W-1:0] len_i,
    input  nav_e             nav_i,
    output logic             close_o,
    output logic [2:0]       nav_len_o,
    output logic [6:0]       nav_pat_o,
    output logic [CTR_W-1:0] long_len_o,
    output logic             long_shift_o,
    output logic             release_o,
    output logic             hold_rst_o,
    output nav_e             nav_o
);
    logic closes;

    always_comb begin
        closes = (op_i == OP_RUN) || (op_i == OP_IR) ||
                 (op_i == OP_DR)  || (op_i == OP_COMMIT);
        close_o      = closes && (nav_i == NAV_DATA);
        nav_len_o    = 3'd0;
        nav_pat_o    = 7'd0;
        long_len_o   = '0;
        long_shift_o = (op_i == OP_SHIFT);
        release_o    = (op_i == OP_BRINGUP);
        hold_rst_o   = (op_i == OP_RESET) || (op_i == OP_BRINGUP);
        nav_o        = nav_i;
        case (op_i)
            OP_RESET: begin
                nav_len_o = 3'd7;
                nav_pat_o = PAT_RESET;
                nav_o     = NAV_RST;
            end
            OP_BRINGUP: begin
                nav_len_o  = 3'd7;
                nav_pat_o  = PAT_RESET;
                long_len_o = CTR_W'(BRINGUP_IDLE);
                nav_o      = NAV_RUN;
            end
            OP_IR: begin
                nav_len_o = 3'd3;
                nav_pat_o = PAT_IR;
                nav_o     = NAV_DATA;
            end
            OP_DR: begin
                nav_len_o = 3'd2;
                nav_pat_o = PAT_DR;
                nav_o     = NAV_DATA;
            end
            OP_RUN: begin
                long_len_o = CTR_W'(len_i);
                nav_o      = NAV_RUN;
            end
            OP_SHIFT: begin
                if (CTR_W'(len_i) > CTR_W'(DW)) begin
                    long_len_o = CTR_W'(DW);
                end else begin
                    long_len_o = CTR_W'(len_i);
                end
            end
            OP_COMMIT: begin
                if (nav_i == NAV_DATA) begin
                    nav_o = NAV_COMMIT;
                end
            end
            default: begin
                nav_o = nav_i;
            end
        endcase
    end

endmodule

// File: rtl/jtag_tap_master.sv
module jtag_tap_master
    import jtag_tap_pkg::*;
#(
    parameter int HALF_PERIOD  = 4,
    parameter int CNT_W        = 8,
    parameter int DW           = 32,
    parameter int BRINGUP_IDLE = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    output logic             cmd_ready_o,
    input  logic [2:0]       cmd_op_i,
    input  logic [CNT_W-1:0] cmd_len_i,
    input  logic [DW-1:0]    cmd_wdata_i,
    output logic             done_o,
    output logic [DW-1:0]    rdata_o,
    output logic             tck_o,
    output logic             tms_o,
    output logic             tdi_o,
    output logic             trst_n_o,
    input  logic             tdo_i
);
    localparam int IDLE_W = $clog2(BRINGUP_IDLE + 1);
    localparam int LEN_W  = (CNT_W > $clog2(DW + 1)) ? CNT_W : $clog2(DW + 1);
    localparam int CTR_W  = (IDLE_W > LEN_W) ? IDLE_W : LEN_W;
    localparam int IW     = (DW > 1) ? $clog2(DW) : 1;

    // Stage order inside one command: close, navigate, long run or shift, finish.
    localparam logic [1:0] STG_CLOSE = 2'd0;
    localparam logic [1:0] STG_NAV   = 2'd1;
    localparam logic [1:0] STG_LONG  = 2'd2;

    typedef struct packed {
        logic             busy;
        logic [1:0]       stg;
        logic             loaded;
        logic [CTR_W-1:0] rem;
        logic [6:0]       tmsp;
        logic [DW-1:0]    tdisr;
        logic [DW-1:0]    cap;
        logic [IW-1:0]    cidx;
        logic             tms;
        logic             tdi;
        logic             trst_n;
        nav_e             nav;
        logic             done;
        logic             close;
        logic [2:0]       nlen;
        logic [6:0]       npat;
        logic [CTR_W-1:0] llen;
        logic             lshift;
        logic             rel;
    } ctl_t;

    ctl_t q, d;

    logic             p_close, p_lshift, p_rel, p_hold;
    logic [2:0]       p_nlen;
    logic [6:0]       p_npat;
    logic [CTR_W-1:0] p_llen;
    nav_e             p_nav;
    logic             start, pul_rise, pul_fin, pul_busy, slot_free;

    jtag_cmd_plan #(
        .CNT_W        (CNT_W),
        .DW           (DW),
        .CTR_W        (CTR_W),
        .BRINGUP_IDLE (BRINGUP_IDLE)
    ) u_plan (
        .op_i         (cmd_op_i),
        .len_i        (cmd_len_i),
        .nav_i        (q.nav),
        .close_o      (p_close),
        .nav_len_o    (p_nlen),
        .nav_pat_o    (p_npat),
        .long_len_o   (p_llen),
        .long_shift_o (p_lshift),
        .release_o    (p_rel),
        .hold_rst_o   (p_hold),
        .nav_o        (p_nav)
    );

    jtag_tck_pulser #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_pulser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .tck_o   (tck_o),
        .rise_o  (pul_rise),
        .fin_o   (pul_fin),
        .busy_o  (pul_busy)
    );

    assign slot_free = !pul_busy || pul_fin;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = 1'b0;
        if (!q.busy) begin
            if (cmd_valid_i) begin
                d.busy   = 1'b1;
                d.stg    = STG_CLOSE;
                d.loaded = 1'b0;
                d.close  = p_close;
                d.nlen   = p_nlen;
                d.npat   = p_npat;
                d.llen   = p_llen;
                d.lshift = p_lshift;
                d.rel    = p_rel;
                d.nav    = p_nav;
                d.tdisr  = cmd_wdata_i;
                d.cap    = '0;
                d.cidx   = '0;
                if (p_hold) begin
                    d.trst_n = 1'b0;
                    d.tdi    = 1'b1;
                end else begin
                    d.trst_n = 1'b1;
                end
            end
        end else if (!q.loaded) begin
            d.loaded = 1'b1;
            case (q.stg)
                STG_CLOSE: begin
                    d.rem  = q.close ? CTR_W'(2) : '0;
                    d.tmsp = PAT_CLOSE;
                end
                STG_NAV: begin
                    d.rem  = CTR_W'(q.nlen);
                    d.tmsp = q.npat;
                end
                STG_LONG: begin
                    d.rem  = q.llen;
                    d.tmsp = '0;
                    if (q.rel) begin
                        d.trst_n = 1'b1;
                    end
                end
                default: begin
                    d.busy   = 1'b0;
                    d.loaded = 1'b0;
                    d.done   = 1'b1;
                end
            endcase
        end else if (slot_free) begin
            if (q.rem != '0) begin
                start  = 1'b1;
                d.tms  = q.tmsp[0];
                d.tmsp = q.tmsp >> 1;
                d.rem  = q.rem - 1'b1;
                if ((q.stg == STG_LONG) && q.lshift) begin
                    d.tdi   = q.tdisr[0];
                    d.tdisr = q.tdisr >> 1;
                end
            end else begin
                d.stg    = q.stg + 2'd1;
                d.loaded = 1'b0;
            end
        end
        if (pul_rise && (q.stg == STG_LONG) && q.lshift) begin
            d.cap[q.cidx] = tdo_i;
            d.cidx        = q.cidx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.tdi <= 1'b1;
            q.nav <= NAV_RST;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready_o = !q.busy;
    assign done_o      = q.done;
    assign rdata_o     = q.cap;
    assign tms_o       = q.tms;
    assign tdi_o       = q.tdi;
    assign trst_n_o    = q.trst_n;

    a_r7_pins_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        tck_o |-> ($stable(tms_o) && $stable(tdi_o)));
    a_r10_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> !tck_o);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_trst_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trst_n_o) |-> !tck_o);
    a_r6_shift_tms_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pul_rise && (q.stg == STG_LONG)) |-> !tms_o);

endmodule

// File: tb/jtag_tap_master_test.sv
module jtag_tap_master_test;
    localparam int HALF  = 4;
    localparam int CNT_W = 8;
    localparam int DW    = 32;
    localparam int IDLE  = 100;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic             cmd_valid;
    logic             cmd_ready_o;
    logic [2:0]       cmd_op;
    logic [CNT_W-1:0] cmd_len;
    logic [DW-1:0]    cmd_wdata;
    logic             done_o;
    logic [DW-1:0]    rdata_o;
    logic             tck_o, tms_o, tdi_o, trst_n_o, tdo;

    logic [31:0] tdo_pat = 32'h0;
    int          tdo_idx = 0;
    assign tdo = tdo_pat[tdo_idx[4:0]];

    jtag_tap_master #(
        .HALF_PERIOD  (HALF),
        .CNT_W        (CNT_W),
        .DW           (DW),
        .BRINGUP_IDLE (IDLE)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_ready_o (cmd_ready_o),
        .cmd_op_i    (cmd_op),
        .cmd_len_i   (cmd_len),
        .cmd_wdata_i (cmd_wdata),
        .done_o      (done_o),
        .rdata_o     (rdata_o),
        .tck_o       (tck_o),
        .tms_o       (tms_o),
        .tdi_o       (tdi_o),
        .trst_n_o    (trst_n_o),
        .tdo_i       (tdo)
    );

    int n_vec = 0;
    int n_bad = 0;

    typedef struct packed {
        logic tms;
        logic tdi;
        logic trst;
    } pin_t;
    pin_t exp_q[$];

    // Reference model state: 0 reset, 1 committed, 2 running, 3 in-data.
    int          nav_m  = 0;
    logic        tdi_m  = 1'b1;
    logic        trst_m = 1'b0;
    logic [31:0] exp_cap;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic pushn(int n, logic tms);
        for (int i = 0; i < n; i++) exp_q.push_back('{tms, tdi_m, trst_m});
    endtask

    task automatic model(int op, int len, logic [31:0] data, int off);
        exp_cap = 32'h0;
        if (op == 0 || op == 6) begin
            trst_m = 1'b0;
            tdi_m  = 1'b1;
            pushn(5, 1'b1);
            pushn(2, 1'b0);
            nav_m = 0;
            if (op == 6) begin
                trst_m = 1'b1;
                pushn(IDLE, 1'b0);
                nav_m = 2;
            end
        end else begin
            trst_m = 1'b1;
            if ((op == 1 || op == 2 || op == 3 || op == 5) && nav_m == 3) begin
                pushn(2, 1'b1);
                if (op == 5) nav_m = 1;
            end
            if (op == 2) begin
                pushn(2, 1'b1); pushn(1, 1'b0); nav_m = 3;
            end else if (op == 3) begin
                pushn(1, 1'b1); pushn(1, 1'b0); nav_m = 3;
            end else if (op == 1) begin
                pushn(len, 1'b0); nav_m = 2;
            end else if (op == 4) begin
                int n;
                n = (len > 32) ? 32 : len;
                for (int b = 0; b < n; b++) begin
                    tdi_m = data[b];
                    pushn(1, 1'b0);
                    exp_cap[b] = tdo_pat[(off + b) % 32];
                end
            end
        end
    endtask

    task automatic wait_done(string tag);
        while (!done_o) @(negedge clk);
        chk({tag, " capture"}, rdata_o, exp_cap);
        chk({tag, " pulse count"}, exp_q.size(), 0);
    endtask

    task automatic issue(int op, int len, logic [31:0] data, logic [31:0] pat, string tag);
        @(negedge clk);
        while (!cmd_ready_o) @(negedge clk);
        tdo_pat = pat;
        tdo_idx = 0;
        model(op, len, data, 0);
        cmd_valid = 1'b1;
        cmd_op    = op[2:0];
        cmd_len   = len[CNT_W-1:0];
        cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 ready low while busy", {31'b0, cmd_ready_o}, 32'h0);
        wait_done(tag);
    endtask

    // Monitor: pops one expected pin set per rising test clock, checks widths.
    initial begin
        logic prev = 1'b0;
        int   low_len = 1000;
        int   high_len = 0;
        forever begin
            @(negedge clk);
            if (tck_o !== prev) begin
                if (tck_o) begin
                    chk("R7 low before rise", {31'b0, low_len >= HALF}, 32'h1);
                    if (exp_q.size() == 0) begin
                        chk("R10 unexpected pulse", 32'h1, 32'h0);
                    end else begin
                        pin_t e;
                        e = exp_q.pop_front();
                        chk("pins R2 R3 R4 R5 R6 R8 R9", {29'b0, tms_o, tdi_o, trst_n_o},
                            {29'b0, e.tms, e.tdi, e.trst});
                    end
                    high_len = 1;
                end else begin
                    chk("R7 high width", high_len, HALF);
                    low_len = 1;
                    tdo_idx++;
                end
                prev = tck_o;
            end else if (tck_o) begin
                high_len++;
            end else begin
                low_len++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R10: got %0d cycles expected fewer", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = '0;
        cmd_len   = '0;
        cmd_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 tck", {31'b0, tck_o}, 32'h0);
        chk("R1 tms", {31'b0, tms_o}, 32'h0);
        chk("R1 tdi", {31'b0, tdi_o}, 32'h1);
        chk("R1 trst", {31'b0, trst_n_o}, 32'h0);
        chk("R1 ready", {31'b0, cmd_ready_o}, 32'h1);
        chk("R1 done", {31'b0, done_o}, 32'h0);
        chk("R1 capture", rdata_o, 32'h0);
        rst_n = 1'b1;

        issue(5, 0, 32'h0, 32'h0, "R3 close while reset");
        issue(6, 0, 32'h0, 32'h0, "R8 bring-up");
        chk("R8 trst released", {31'b0, trst_n_o}, 32'h1);
        issue(3, 0, 32'h0, 32'h0, "R4 data path from run");
        issue(4, 8, 32'h000000A5, 32'h3C3C_1E0F, "R6 shift 8");
        issue(2, 0, 32'h0, 32'h0, "R4 instruction path with auto close");
        issue(4, 32, 32'hDEAD_BEEF, 32'h1234_5678, "R6 shift 32");
        issue(5, 0, 32'h0, 32'h0, "R3 close open shift");
        issue(5, 0, 32'h0, 32'h0, "R3 close when committed");
        issue(1, 5, 32'h0, 32'h0, "R5 idle 5");
        issue(3, 0, 32'h0, 32'h0, "R4 data path");
        issue(4, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 shift 0");
        issue(1, 0, 32'h0, 32'h0, "R5 idle 0 closes only");
        issue(0, 0, 32'h0, 32'h0, "R2 chain reset");
        chk("R9 trst held after reset", {31'b0, trst_n_o}, 32'h0);
        issue(5, 0, 32'h0, 32'h0, "R2 close after reset");
        chk("R9 trst raised by next command", {31'b0, trst_n_o}, 32'h1);
        issue(3, 0, 32'h0, 32'h0, "R4 data path again");
        issue(4, 40, 32'hF0F0_F0F1, 32'h0FF0_0FF0, "R6 shift clamp 32");
        issue(7, 9, 32'h0, 32'hFFFF_FFFF, "R10 unused opcode");

        // Back to back: data path with auto close, then a shift taken in the done cycle.
        @(negedge clk);
        while (!cmd_ready_o) @(negedge clk);
        tdo_pat = 32'h9A5C_3E71;
        tdo_idx = 0;
        model(3, 0, 32'h0, 0);
        cmd_valid = 1'b1;
        cmd_op    = 3'd3;
        cmd_len   = '0;
        cmd_wdata = '0;
        @(negedge clk);
        cmd_op    = 3'd4;
        cmd_len   = 8'd12;
        cmd_wdata = 32'h0000_0B3D;
        chk("R10 ready low after first accept", {31'b0, cmd_ready_o}, 32'h0);
        while (!done_o) @(negedge clk);
        chk("R10 first capture", rdata_o, 32'h0);
        chk("R4 first pulse count", exp_q.size(), 0);
        chk("R10 ready in done cycle", {31'b0, cmd_ready_o}, 32'h1);
        model(4, 12, 32'h0000_0B3D, 4);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 second accepted in done cycle", {31'b0, cmd_ready_o}, 32'h0);
        wait_done("R6 R10 back-to-back shift");

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule